// File: doc/BRIEF.md
# Serial Gain and Bias Control Register

This block is the write-only control port of a variable-gain line driver. Three control lines arrive from outside the chip: a serial clock, a serial data line and an active-low load enable. They are sampled by the block's own system clock through a synchronizer, together with the transmit-enable and sleep lines. When the enable goes low a load window opens, and eight data bits are shifted in, most significant bit first. When the enable rises again, the word is committed to a holding register, but only if exactly eight bits arrived. At that point the shifter is frozen until the next window.

The committed word carries a two-bit output-stage current preset and a six-bit gain code. The gain code is forced into its legal range of 1 to 60 and is then split into a coarse count of 6 dB attenuation steps and a fine count of 1 dB vernier steps. A sticky flag marks a clamped code and another sticky flag marks a badly framed load. The transmit-enable and sleep lines are combined with a "word committed" flag, so the driver cannot transmit at an undefined gain. The combination gives an effective transmit enable and a three-way power state.

Top module: `gain_bias_ctl`

## Requirements
- R1: A falling edge on `ld_en_n` opens a load window. Within the window, each rising edge of `ser_clk` shifts `ser_din` into an 8-bit register, most significant bit first. The first bit lands in word bit 7.
- R2: A rising edge on `ld_en_n` that follows exactly 8 shifted bits commits the word. Clock edges while `ld_en_n` is high shift nothing and change no output.
- R3: While a load window is open, all decoded outputs keep their last committed values.
- R4: Word bits [7:6] drive `cur_level` (0 lowest to 3 highest). Bits [5:0] are the raw gain code.
- R5: A raw gain code of 0 commits as 1, and codes 61 to 63 commit as 60. Any such clamp sets the sticky `range_err`.
- R6: `coarse_steps` = (60 - code) / 6 and `fine_steps` = (60 - code) % 6. Both are registered together with `gain_code`.
- R7: Reset leaves `word_valid`=0, `cur_level`=0, `gain_code`=1, `coarse_steps`=9, `fine_steps`=5, and both error flags at 0. The first good commit sets `word_valid`, and it then stays set.
- R8: `tx_active` is 1 only when `tx_en`, `sleep_n` and `word_valid` are all 1.
- R9: `pwr_state` is encoded as 0 when `sleep_n` is low (sleep), 2 when `tx_active` conditions hold (active), and 1 otherwise (standby).
- R10: A rising `ld_en_n` after any bit count other than 8 commits nothing and sets the sticky `frame_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_din | input | 1 | Serial data, MSB first |
| ld_en_n | input | 1 | Active-low load enable; rising edge commits |
| tx_en | input | 1 | Transmit enable request (asynchronous) |
| sleep_n | input | 1 | Low requests full power-down (asynchronous) |
| cur_level | output | 2 | Committed output-stage current preset |
| gain_code | output | 6 | Committed, clamped gain code (1..60) |
| coarse_steps | output | 4 | Number of 6 dB attenuation steps |
| fine_steps | output | 3 | Number of 1 dB vernier steps |
| word_valid | output | 1 | A word has been committed since reset |
| range_err | output | 1 | Sticky: a committed gain code was clamped |
| frame_err | output | 1 | Sticky: a load closed with the wrong bit count |
| tx_active | output | 1 | Effective transmit enable |
| pwr_state | output | 2 | 0 sleep, 1 standby, 2 active |

## Verification
Some properties are checked on every cycle. The shifter stays frozen whenever no window is open, and a taken bit enters at the low end of the register. The holding register changes only on a commit, and the committed code always stays within 1 to 60. The coarse and fine counts always recombine to the attenuation, a framing fault always leaves the sticky flag set, and transmission is never active without a committed word or while asleep. Other behaviour is shown only by the bench's scenarios: the actual values of decoded words, the clamp of edge codes, the rejection of short and long loads, the outputs staying unchanged during a half-loaded window, and the power state following its inputs.

// File: rtl/gbc_pkg.sv
package gbc_pkg;
  localparam int WORD_W   = 8;
  localparam int LVL_W    = 2;
  localparam int CODE_W   = WORD_W - LVL_W;
  localparam int CODE_MIN = 1;
  localparam int CODE_MAX = 60;
  localparam int STEP_DB  = 6;
  localparam int ATT_MAX  = CODE_MAX - CODE_MIN;
  localparam int COARSE_W = $clog2(ATT_MAX / STEP_DB + 1);
  localparam int FINE_W   = $clog2(STEP_DB);
  localparam int CNT_W    = $clog2(WORD_W + 1) + 1;

  typedef enum logic [1:0] {
    PWR_SLEEP   = 2'd0,
    PWR_STANDBY = 2'd1,
    PWR_ACTIVE  = 2'd2
  } pwr_e;

  function automatic logic code_bad(input logic [CODE_W-1:0] raw);
    return (int'(raw) < CODE_MIN) || (int'(raw) > CODE_MAX);
  endfunction

  function automatic logic [CODE_W-1:0] clamp_code(input logic [CODE_W-1:0] raw);
    if (int'(raw) < CODE_MIN) return CODE_W'(CODE_MIN);
    if (int'(raw) > CODE_MAX) return CODE_W'(CODE_MAX);
    return raw;
  endfunction

  function automatic logic [COARSE_W-1:0] coarse_of(input logic [CODE_W-1:0] code);
    return COARSE_W'((CODE_MAX - int'(code)) / STEP_DB);
  endfunction

  function automatic logic [FINE_W-1:0] fine_of(input logic [CODE_W-1:0] code);
    return FINE_W'((CODE_MAX - int'(code)) % STEP_DB);
  endfunction
endpackage

// File: rtl/gbc_sync.sv
module gbc_sync #(
  parameter int              W       = 1,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) st[i] <= RST_VAL;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/gbc_shifter.sv
module gbc_shifter
  import gbc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_clk,
  input  logic              s_din,
  input  logic              s_en_n,
  output logic [WORD_W-1:0] word,
  output logic              commit,
  output logic              frame_bad
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] CNT_SAT  = '1;

  logic              clk_q, en_q, win;
  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-1:0] sh;

  wire clk_rise = s_clk & ~clk_q;
  wire en_fall  = ~s_en_n & en_q;
  wire en_rise  = s_en_n & ~en_q;
  wire take     = clk_rise & win & ~s_en_n & ~en_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_q <= 1'b0;
      en_q  <= 1'b1;
      win   <= 1'b0;
      cnt   <= '0;
      sh    <= '0;
    end else begin
      clk_q <= s_clk;
      en_q  <= s_en_n;
      if (en_fall) begin
        win <= 1'b1;
        cnt <= '0;
      end else if (en_rise) begin
        win <= 1'b0;
      end else if (take) begin
        sh <= {sh[WORD_W-2:0], s_din};
        if (cnt != CNT_SAT) cnt <= cnt + 1'b1;
      end
    end
  end

  assign commit    = en_rise & win & (cnt == CNT_FULL);
  assign frame_bad = en_rise & win & (cnt != CNT_FULL);
  assign word      = sh;

  // R2: shifter frozen outside a load window
  assert_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !win |=> $stable(sh));
  // R1: a taken bit enters at the low end
  assert_shift_in_R1: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> sh[0] == $past(s_din));
  assert_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit && frame_bad));
endmodule

// File: rtl/gbc_decode.sv
module gbc_decode
  import gbc_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                commit,
  input  logic                frame_bad,
  input  logic [WORD_W-1:0]   word,
  output logic [LVL_W-1:0]    cur_level,
  output logic [CODE_W-1:0]   gain_code,
  output logic [COARSE_W-1:0] coarse_steps,
  output logic [FINE_W-1:0]   fine_steps,
  output logic                word_valid,
  output logic                range_err,
  output logic                frame_err
);
  wire [CODE_W-1:0] raw  = word[CODE_W-1:0];
  wire [CODE_W-1:0] safe = clamp_code(raw);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_level    <= '0;
      gain_code    <= CODE_W'(CODE_MIN);
      coarse_steps <= coarse_of(CODE_W'(CODE_MIN));
      fine_steps   <= fine_of(CODE_W'(CODE_MIN));
      word_valid   <= 1'b0;
      range_err    <= 1'b0;
      frame_err    <= 1'b0;
    end else begin
      if (commit) begin
        cur_level    <= word[WORD_W-1:CODE_W];
        gain_code    <= safe;
        coarse_steps <= coarse_of(safe);
        fine_steps   <= fine_of(safe);
        word_valid   <= 1'b1;
        if (code_bad(raw)) range_err <= 1'b1;
      end
      if (frame_bad) frame_err <= 1'b1;
    end
  end

  // R3: holding register changes only on commit
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable({cur_level, gain_code, coarse_steps, fine_steps}));
  assert_code_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(gain_code) >= CODE_MIN) && (int'(gain_code) <= CODE_MAX));
  assert_split_R6: assert property (@(posedge clk) disable iff (!rst_n)
    int'(coarse_steps) * STEP_DB + int'(fine_steps) == CODE_MAX - int'(gain_code));
  assert_frame_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_bad |=> frame_err);
  assert_valid_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> word_valid);
endmodule

// File: rtl/gain_bias_ctl.sv
module gain_bias_ctl
  import gbc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ser_clk,
  input  logic       ser_din,
  input  logic       ld_en_n,
  input  logic       tx_en,
  input  logic       sleep_n,
  output logic [1:0] cur_level,
  output logic [5:0] gain_code,
  output logic [3:0] coarse_steps,
  output logic [2:0] fine_steps,
  output logic       word_valid,
  output logic       range_err,
  output logic       frame_err,
  output logic       tx_active,
  output logic [1:0] pwr_state
);
  localparam int NSYNC = 5;

  logic [NSYNC-1:0] s_bus;
  logic             s_clk, s_din, s_en_n, s_tx, s_slp;
  logic [WORD_W-1:0] word;
  logic             commit, frame_bad;

  gbc_sync #(.W(NSYNC), .STAGES(SYNC_STAGES), .RST_VAL(5'b00100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({ser_clk, ser_din, ld_en_n, tx_en, sleep_n}),
    .q(s_bus)
  );
  assign {s_clk, s_din, s_en_n, s_tx, s_slp} = s_bus;

  gbc_shifter u_shift (
    .clk(clk), .rst_n(rst_n),
    .s_clk(s_clk), .s_din(s_din), .s_en_n(s_en_n),
    .word(word), .commit(commit), .frame_bad(frame_bad)
  );

  gbc_decode u_dec (
    .clk(clk), .rst_n(rst_n),
    .commit(commit), .frame_bad(frame_bad), .word(word),
    .cur_level(cur_level), .gain_code(gain_code),
    .coarse_steps(coarse_steps), .fine_steps(fine_steps),
    .word_valid(word_valid), .range_err(range_err), .frame_err(frame_err)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_active <= 1'b0;
      pwr_state <= PWR_SLEEP;
    end else begin
      tx_active <= s_tx & s_slp & word_valid;
      if (!s_slp)                   pwr_state <= PWR_SLEEP;
      else if (s_tx && word_valid)  pwr_state <= PWR_ACTIVE;
      else                          pwr_state <= PWR_STANDBY;
    end
  end

  // R8: never transmitting without a committed word
  assert_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_active |-> word_valid);
  // R9: sleep state excludes transmission
  assert_sleep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == PWR_SLEEP) |-> !tx_active);
  assert_enc_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_state != 2'd3);
endmodule

// File: tb/tb_gain_bias_ctl.sv
module tb_gain_bias_ctl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_din = 1'b0, ld_en_n = 1'b1, tx_en = 1'b0, sleep_n = 1'b0;
  logic [1:0] cur_level;
  logic [5:0] gain_code;
  logic [3:0] coarse_steps;
  logic [2:0] fine_steps;
  logic word_valid, range_err, frame_err, tx_active;
  logic [1:0] pwr_state;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;
  bit exp_rerr = 0;
  int exp_lvl, exp_code;

  always #2.5 clk = ~clk;

  gain_bias_ctl dut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_din(ser_din),
    .ld_en_n(ld_en_n), .tx_en(tx_en), .sleep_n(sleep_n),
    .cur_level(cur_level), .gain_code(gain_code), .coarse_steps(coarse_steps),
    .fine_steps(fine_steps), .word_valid(word_valid), .range_err(range_err),
    .frame_err(frame_err), .tx_active(tx_active), .pwr_state(pwr_state)
  );

  localparam int NV = 8;
  localparam logic [7:0] VEC [NV] = '{
    8'hFC, 8'h01, 8'h9C, 8'h40, 8'hFF, 8'h7D, 8'h2A, 8'hC7
  };

  task automatic check(string req, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_bit(logic b);
    ser_din = b;  wait_n(4);
    ser_clk = 1'b1; wait_n(4);
    ser_clk = 1'b0;
  endtask

  task automatic send_word(logic [7:0] w, int nbits);
    ld_en_n = 1'b0; wait_n(4);
    for (int i = 0; i < nbits; i++) pulse_bit(i < 8 ? w[7-i] : 1'b1);
    wait_n(4);
    ld_en_n = 1'b1; wait_n(8);
  endtask

  function automatic int ref_code(int raw);
    if (raw == 0) return 1;
    if (raw > 60) return 60;
    return raw;
  endfunction

  task automatic check_latched(string req);
    int att;
    att = 60 - exp_code;
    check({req, " level"}, cur_level, exp_lvl);
    check({req, " code"}, gain_code, exp_code);
    check({req, " coarse"}, coarse_steps, att / 6);
    check({req, " fine"}, fine_steps, att - 6 * (att / 6));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    wait_n(4);
    rst_n = 1'b1;
    wait_n(8);
    // R7: reset state
    exp_lvl = 0; exp_code = 1;
    check_latched("R7 reset");
    check("R7 valid at reset", word_valid, 0);
    check("R7 range_err at reset", range_err, 0);
    check("R7 frame_err at reset", frame_err, 0);
    check("R9 sleep at reset", pwr_state, 0);
    // R8: request transmit before any commit
    sleep_n = 1'b1; tx_en = 1'b1; wait_n(8);
    check("R8 no tx before commit", tx_active, 0);
    check("R9 standby before commit", pwr_state, 1);
    tx_en = 1'b0; wait_n(8);

    // R1 R4 R5 R6: vector table
    for (int v = 0; v < NV; v++) begin
      send_word(VEC[v], 8);
      exp_lvl  = int'(VEC[v][7:6]);
      exp_code = ref_code(int'(VEC[v][5:0]));
      if (VEC[v][5:0] == 6'd0 || VEC[v][5:0] > 6'd60) exp_rerr = 1;
      check_latched("R4 R6 vector");
      check("R5 range_err", range_err, int'(exp_rerr));
      check("R7 valid after commit", word_valid, 1);
    end

    // R3: outputs held while window is half loaded
    ld_en_n = 1'b0; wait_n(4);
    for (int i = 0; i < 4; i++) pulse_bit(i[0] ? 1'b1 : 1'b0);
    wait_n(6);
    check_latched("R3 mid-window");
    for (int i = 4; i < 8; i++) pulse_bit(i[0] ? 1'b1 : 1'b0);
    wait_n(4); ld_en_n = 1'b1; wait_n(8);
    exp_lvl = 1; exp_code = 21;   // 0x55
    check_latched("R1 R2 commit 0x55");

    // R10: short and long loads rejected
    send_word(8'hFC, 5);
    check_latched("R10 short load");
    check("R10 frame_err short", frame_err, 1);
    send_word(8'hFC, 9);
    check_latched("R10 long load");
    check("R10 frame_err long", frame_err, 1);

    // R2: clocks with enable high
    for (int i = 0; i < 8; i++) pulse_bit(1'b1);
    wait_n(8);
    check_latched("R2 clocks while closed");

    // R8 R9: power combinations
    tx_en = 1'b1; wait_n(8);
    check("R8 tx active", tx_active, 1);
    check("R9 active", pwr_state, 2);
    tx_en = 1'b0; wait_n(8);
    check("R8 tx dropped", tx_active, 0);
    check("R9 standby", pwr_state, 1);
    sleep_n = 1'b0; wait_n(8);
    check("R9 sleep", pwr_state, 0);
    tx_en = 1'b1; wait_n(8);
    check("R8 tx blocked by sleep", tx_active, 0);
    check("R9 sleep with tx_en", pwr_state, 0);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule